// File: doc/BRIEF.md
# Scanline Fetch Controller for a Double-Data-Rate Burst DRAM

This block fills a line buffer with one display line of 8-bit pixels read from an external burst DRAM with an 8-bit double-data-rate bus. A rising edge on the horizontal sync input starts the fetch. The controller takes the line number from its input and turns it into a word address. It then reads the line as a fixed number of short chip-select transactions, so that no transaction stays selected longer than the device allows. The memory bus runs far faster than the pixel rate, so the whole line arrives well before the next sync.

Each transaction works in four steps. The controller drops chip select while the memory clock is low. It sends a six-byte read command on successive memory clock edges. It lets a programmable number of latency clocks pass with the bus released. It then takes one data byte per clock edge into the line buffer, beginning with the first byte returned. After the final edge the clock rests low. Chip select then rises and stays high for a minimum gap before the next transaction starts. The pixel side reads the buffer through a separate synchronous read port.

The memory clock runs at half the controller clock, so each controller cycle carries one clock edge. The reset, select and clock pins always carry a driven level.

Top module: `hrf_line_fetch`

## Requirements
- R1: While reset is asserted: hrCsN is 1, hrClk is 0, hrRstN is 0, hrDqOe is 0, busy is 0 and overrun is 0. From the first clock edge after reset is released, hrRstN is 1.
- R2: A 0-to-1 change of hsync seen in idle starts a fetch. busy is 1 from the next cycle for exactly NUM_CHUNKS*(7+2*LATENCY_CLKS+CHUNK_BYTES+CS_GAP_CYCLES) cycles, which is 156 with the defaults. busy then returns to 0.
- R3: Each transaction begins with six command bytes, most significant byte first, one on each of the first six hrClk edges, with hrDqOe at 1. In the 48-bit command, bit 47 is 1 (read), bit 46 is 0 (memory space) and bit 45 is 1 (linear burst). Bits 44..16 carry word address bits above bit 2, bits 15..3 are 0, and bits 2..0 carry word address bits 2..0. hrDqOe is never 1 while hrCsN is 1.
- R4: After the command come exactly 2*LATENCY_CLKS hrClk edges with hrDqOe at 0. Then come exactly CHUNK_BYTES data edges. Each transaction therefore has 6+2*LATENCY_CLKS+CHUNK_BYTES edges.
- R5: The byte on data edge d of a transaction is stored in the line buffer at index chunk*CHUNK_BYTES+d, starting with d=0. After a fetch of line n, buffer entry i equals memory byte n*LINE_BYTES+i. rdData shows the entry at rdAddr one cycle after rdAddr is set.
- R6: A line is read as LINE_BYTES/CHUNK_BYTES transactions (4 by default). The first starts at word address n*LINE_BYTES/2, and each later one starts CHUNK_BYTES/2 words above the one before it.
- R7: hrClk is 0 whenever hrCsN is 1. It is also 0 in the cycle before and the cycle of every hrCsN edge, so the last clock edge of every transaction leaves the clock low.
- R8: hrCsN stays low for 7+2*LATENCY_CLKS+CHUNK_BYTES cycles per transaction (35 by default), which never exceeds MAX_CS_CYCLES. Between transactions of one line it stays high for exactly CS_GAP_CYCLES cycles.
- R9: A 0-to-1 change of hsync while busy is 1, including the last busy cycle, sets overrun. overrun then stays 1 until reset. The fetch in progress and the buffer contents are unaffected, and no extra transaction starts.
- R10: hsync held at 1 for longer than a fetch starts only one fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync; a rising edge starts a line fetch |
| lineNum | input | LINE_W | Line to fetch, taken at the start edge |
| hrRstN | output | 1 | Memory reset, driven low in reset and high after |
| hrCsN | output | 1 | Memory chip select, active low |
| hrClk | output | 1 | Memory clock, half the controller rate |
| hrDqOut | output | 8 | Command bytes toward the memory |
| hrDqOe | output | 1 | Drive enable for hrDqOut |
| hrDqIn | input | 8 | Data bytes from the memory |
| rdAddr | input | BUF_AW | Pixel-side buffer read index |
| rdData | output | 8 | Buffer byte, one cycle after rdAddr |
| busy | output | 1 | Line fetch in progress |
| overrun | output | 1 | Sticky: a sync edge arrived while busy |

## Verification
The colliding pair is a new sync edge and the end of the current fetch, which meet in the last cycle of the final chip-select gap. The bench counts busy cycles from a measured fetch. It raises hsync exactly in the last busy cycle and expects overrun, an unchanged buffer and no extra transaction. It also raises hsync one cycle later, in the first idle cycle, and expects a clean new fetch with overrun still 0. A behavioural memory model on the bench's side decodes each command, counts clock edges per transaction and serves address-derived bytes. The buffer is then compared against those bytes.

// File: rtl/hrf_pkg.sv
`timescale 1ns/1ps
package hrf_pkg;
  localparam int CMD_BYTES = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_LAT, ST_DATA, ST_HOLD, ST_GAP
  } fetchState_t;

  typedef struct packed {
    logic latchLine;  // take lineNum and reset the buffer write index
    logic cmdEdge;    // a command byte goes out with this clock edge
    logic dataEdge;   // a data byte is returned on this clock edge
    logic nextChunk;  // the transaction is ending; step the address
  } fetchStrobe_t;
endpackage

// File: rtl/hrf_ctrl.sv
`timescale 1ns/1ps
module hrf_ctrl
  import hrf_pkg::*;
#(
  parameter int LINE_BYTES    = 64,
  parameter int CHUNK_BYTES   = 16,
  parameter int LATENCY_CLKS  = 6,
  parameter int CS_GAP_CYCLES = 4,
  parameter int MAX_CS_CYCLES = 400
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hsync,
  output fetchStrobe_t strobe,
  output logic [2:0]   cmdIdx,
  output logic         hrRstN,
  output logic         hrCsN,
  output logic         hrClk,
  output logic         busy,
  output logic         overrun
);
  localparam int NUM_CHUNKS = LINE_BYTES / CHUNK_BYTES;
  localparam int LAT_EDGES  = 2 * LATENCY_CLKS;
  localparam int MAX_A      = (LAT_EDGES > CHUNK_BYTES) ? LAT_EDGES : CHUNK_BYTES;
  localparam int MAX_B      = (CS_GAP_CYCLES > CMD_BYTES) ? CS_GAP_CYCLES : CMD_BYTES;
  localparam int MAX_CNT    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W      = $clog2(MAX_CNT + 1);
  localparam int CHK_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
  localparam int MON_W      = 16;

  fetchState_t      state;
  logic [CNT_W-1:0] cnt;
  logic [CHK_W-1:0] chunkCnt;
  logic             hsyncPrev;
  logic             trigger;
  logic             clkToggle;

  assign trigger   = hsync & ~hsyncPrev;
  assign clkToggle = (state == ST_CMD) || (state == ST_LAT) || (state == ST_DATA);
  assign busy      = (state != ST_IDLE);
  assign cmdIdx    = cnt[2:0];

  always_comb begin
    strobe.latchLine = (state == ST_IDLE) && trigger;
    strobe.cmdEdge   = (state == ST_CMD);
    strobe.dataEdge  = (state == ST_DATA);
    strobe.nextChunk = (state == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      chunkCnt  <= '0;
      hrCsN     <= 1'b1;
      hrClk     <= 1'b0;
      hsyncPrev <= 1'b0;
      overrun   <= 1'b0;
      hrRstN    <= 1'b0;
    end else begin
      hrRstN    <= 1'b1;
      hsyncPrev <= hsync;
      hrClk     <= hrClk ^ clkToggle;
      if (trigger && state != ST_IDLE) overrun <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (trigger) begin
            state    <= ST_CMD;
            cnt      <= '0;
            chunkCnt <= '0;
            hrCsN    <= 1'b0;
          end
        end
        ST_CMD: begin
          if (cnt == CNT_W'(CMD_BYTES - 1)) begin
            state <= ST_LAT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_LAT: begin
          if (cnt == CNT_W'(LAT_EDGES - 1)) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          if (cnt == CNT_W'(CHUNK_BYTES - 1)) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_HOLD: begin
          state <= ST_GAP;
          cnt   <= '0;
          hrCsN <= 1'b1;
        end
        ST_GAP: begin
          if (cnt == CNT_W'(CS_GAP_CYCLES - 1)) begin
            cnt <= '0;
            if (chunkCnt == CHK_W'(NUM_CHUNKS - 1)) begin
              state <= ST_IDLE;
            end else begin
              state    <= ST_CMD;
              chunkCnt <= chunkCnt + 1'b1;
              hrCsN    <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Monitoring counters for the select-window checks below.
  logic [MON_W-1:0] csLowCnt;
  logic [MON_W-1:0] csHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLowCnt  <= '0;
      csHighCnt <= '1;
    end else if (hrCsN) begin
      csLowCnt  <= '0;
      if (csHighCnt != '1) csHighCnt <= csHighCnt + 1'b1;
    end else begin
      csHighCnt <= '0;
      if (csLowCnt != '1) csLowCnt <= csLowCnt + 1'b1;
    end
  end

  assert_clk_low_cs_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hrCsN) |-> (!hrClk && !$past(hrClk)));
  assert_clk_low_cs_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hrCsN) |-> (!hrClk && !$past(hrClk)));
  assert_clk_idle_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    hrCsN |-> !hrClk);
  assert_cs_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hrCsN |-> (csLowCnt < MON_W'(MAX_CS_CYCLES)));
  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hrCsN) |-> (csHighCnt >= MON_W'(CS_GAP_CYCLES)));
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !busy) |=> (busy && !hrCsN));
endmodule

// File: rtl/hrf_line_buf.sv
`timescale 1ns/1ps
module hrf_line_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/hrf_datapath.sv
`timescale 1ns/1ps
module hrf_datapath
  import hrf_pkg::*;
#(
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  parameter int LINE_W      = 10,
  parameter int ADDR_W      = 24,
  parameter int BUF_AW      = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      strobe,
  input  logic [2:0]        cmdIdx,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [7:0]        hrDqIn,
  output logic [7:0]        hrDqOut,
  output logic              hrDqOe,
  input  logic [BUF_AW-1:0] rdAddr,
  output logic [7:0]        rdData
);
  localparam int HALF_LINE  = LINE_BYTES / 2;
  localparam int HALF_CHUNK = CHUNK_BYTES / 2;

  logic [ADDR_W-1:0] chunkAddr;
  logic [31:0]       addrWide;
  logic [47:0]       cmdWord;
  logic [7:0]        cmdByte;
  logic              capValid;
  logic [BUF_AW-1:0] wrPtr;

  assign addrWide = 32'(chunkAddr);
  // read, memory space, linear burst; upper address, reserved zeros, low column
  assign cmdWord  = {3'b101, addrWide[31:3], 13'd0, addrWide[2:0]};

  always_comb begin
    case (cmdIdx)
      3'd0:    cmdByte = cmdWord[47:40];
      3'd1:    cmdByte = cmdWord[39:32];
      3'd2:    cmdByte = cmdWord[31:24];
      3'd3:    cmdByte = cmdWord[23:16];
      3'd4:    cmdByte = cmdWord[15:8];
      default: cmdByte = cmdWord[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chunkAddr <= '0;
      hrDqOut   <= '0;
      hrDqOe    <= 1'b0;
      capValid  <= 1'b0;
      wrPtr     <= '0;
    end else begin
      hrDqOe   <= strobe.cmdEdge;
      hrDqOut  <= strobe.cmdEdge ? cmdByte : 8'd0;
      // returned byte appears one cycle after its clock edge
      capValid <= strobe.dataEdge;
      if (strobe.latchLine) begin
        chunkAddr <= ADDR_W'(lineNum) * ADDR_W'(HALF_LINE);
        wrPtr     <= '0;
      end else begin
        if (strobe.nextChunk) chunkAddr <= chunkAddr + ADDR_W'(HALF_CHUNK);
        if (capValid) wrPtr <= wrPtr + 1'b1;
      end
    end
  end

  hrf_line_buf #(.DEPTH(LINE_BYTES), .AW(BUF_AW)) i_lineBuf (
    .clk    (clk),
    .wrEn   (capValid),
    .wrAddr (wrPtr),
    .wrData (hrDqIn),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  assert_no_capture_in_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    capValid |-> !hrDqOe);
  assert_line_start_index_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.latchLine) |-> (wrPtr == '0));
endmodule

// File: rtl/hrf_line_fetch.sv
`timescale 1ns/1ps
module hrf_line_fetch
  import hrf_pkg::*;
#(
  parameter int LINE_BYTES    = 64,
  parameter int CHUNK_BYTES   = 16,
  parameter int LATENCY_CLKS  = 6,
  parameter int CS_GAP_CYCLES = 4,
  parameter int MAX_CS_CYCLES = 400,
  parameter int LINE_W        = 10,
  parameter int ADDR_W        = 24,
  parameter int BUF_AW        = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsync,
  input  logic [LINE_W-1:0] lineNum,
  output logic              hrRstN,
  output logic              hrCsN,
  output logic              hrClk,
  output logic [7:0]        hrDqOut,
  output logic              hrDqOe,
  input  logic [7:0]        hrDqIn,
  input  logic [BUF_AW-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              overrun
);
  fetchStrobe_t strobe;
  logic [2:0]   cmdIdx;

  hrf_ctrl #(
    .LINE_BYTES(LINE_BYTES), .CHUNK_BYTES(CHUNK_BYTES), .LATENCY_CLKS(LATENCY_CLKS),
    .CS_GAP_CYCLES(CS_GAP_CYCLES), .MAX_CS_CYCLES(MAX_CS_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .hsync(hsync), .strobe(strobe), .cmdIdx(cmdIdx),
    .hrRstN(hrRstN), .hrCsN(hrCsN), .hrClk(hrClk), .busy(busy), .overrun(overrun)
  );

  hrf_datapath #(
    .LINE_BYTES(LINE_BYTES), .CHUNK_BYTES(CHUNK_BYTES), .LINE_W(LINE_W),
    .ADDR_W(ADDR_W), .BUF_AW(BUF_AW)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdIdx(cmdIdx), .lineNum(lineNum),
    .hrDqIn(hrDqIn), .hrDqOut(hrDqOut), .hrDqOe(hrDqOe),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  assert_bus_inside_cs_R3: assert property (@(posedge clk) disable iff (!rstN)
    hrDqOe |-> !hrCsN);
  assert_busy_covers_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    !hrCsN |-> busy);
endmodule

// File: tb/test_hrf_line_fetch.sv
`timescale 1ns/1ps
module test_hrf_line_fetch;
  localparam int LINE_BYTES = 64;
  localparam int CHUNK      = 16;
  localparam int LAT        = 6;
  localparam int GAP        = 4;
  localparam int NCHUNK     = LINE_BYTES / CHUNK;
  localparam int EDGES      = 6 + 2 * LAT + CHUNK;
  localparam int CS_LOW     = EDGES + 1;
  localparam int BUSY_LEN   = NCHUNK * (CS_LOW + GAP);

  logic       clk = 0;
  logic       rstN = 0;
  logic       hsync = 0;
  logic [9:0] lineNum = '0;
  logic       hrRstN, hrCsN, hrClk, hrDqOe, busy, overrun;
  logic [7:0] hrDqOut, rdData;
  logic [7:0] memDrive = '0;
  logic [5:0] rdAddr = '0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  hrf_line_fetch i_hrf_line_fetch (
    .clk(clk), .rstN(rstN), .hsync(hsync), .lineNum(lineNum),
    .hrRstN(hrRstN), .hrCsN(hrCsN), .hrClk(hrClk), .hrDqOut(hrDqOut), .hrDqOe(hrDqOe),
    .hrDqIn(memDrive), .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .overrun(overrun)
  );

  function automatic logic [7:0] memByte(int a);
    int v;
    v = a * 37 + (a >>> 5) + 11;
    return v[7:0];
  endfunction

  task automatic check(bit ok, string req, string what, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  // Behavioural memory model
  logic        prevClk = 0, prevCs = 1;
  int          edgeCnt = 0, lowRun = 0, highRun = 1000, minGap = 1000;
  int          transCnt = 0, clkBad = 0, oeBad = 0, edgeBad = 0, lowBad = 0;
  int          cmdBad = 0, addrBad = 0, expWord = 0;
  logic [47:0] cmdReg = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevCs && !hrCsN) begin
        if (hrClk || prevClk) clkBad++;
        if (highRun < minGap) minGap = highRun;
        edgeCnt = 0;
        lowRun  = 0;
      end
      if (!prevCs && hrCsN) begin
        if (hrClk || prevClk) clkBad++;
        transCnt++;
        if (lowRun != CS_LOW) lowBad++;
        if (edgeCnt != EDGES) edgeBad++;
        if (cmdReg[47:45] != 3'b101 || cmdReg[15:3] != 13'd0) cmdBad++;
        if (int'({cmdReg[44:16], cmdReg[2:0]}) != expWord) addrBad++;
        expWord += CHUNK / 2;
        highRun = 0;
      end
      if (hrCsN) begin
        if (highRun < 1000) highRun++;
        if (hrClk) clkBad++;
      end else begin
        lowRun++;
        if (hrClk != prevClk) begin
          edgeCnt++;
          if (edgeCnt <= 6) begin
            if (!hrDqOe) oeBad++;
            cmdReg = {cmdReg[39:0], hrDqOut};
          end else if (edgeCnt <= 6 + 2 * LAT) begin
            if (hrDqOe) oeBad++;
          end else begin
            memDrive <= memByte(2 * int'({cmdReg[44:16], cmdReg[2:0]}) + edgeCnt - 7 - 2 * LAT);
          end
        end
      end
    end
    prevClk = hrClk;
    prevCs  = hrCsN;
  end

  task automatic readBuf(int idx, output int val);
    @(negedge clk) rdAddr = 6'(idx);
    @(negedge clk) val = int'(rdData);
  endtask

  task automatic checkLine(int line, string req);
    int v, bad, firstVal;
    bad = 0;
    firstVal = 0;
    for (int i = 0; i < LINE_BYTES; i++) begin
      readBuf(i, v);
      if (i == 0) firstVal = v;
      if (v != int'(memByte(line * LINE_BYTES + i))) bad++;
    end
    check(firstVal == int'(memByte(line * LINE_BYTES)), req, "first byte of line",
          firstVal, int'(memByte(line * LINE_BYTES)));
    check(bad == 0, req, "line buffer mismatches", bad, 0);
  endtask

  // Raise hsync at a negedge for one cycle and return the busy length.
  task automatic fetchLine(int line, output int len);
    lineNum = 10'(line);
    expWord = line * LINE_BYTES / 2;
    hsync = 1;
    @(negedge clk) hsync = 0;
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    check(hrCsN == 1, "R1", "cs in reset", int'(hrCsN), 1);
    check(hrClk == 0, "R1", "clk in reset", int'(hrClk), 0);
    check(hrRstN == 0, "R1", "mem reset in reset", int'(hrRstN), 0);
    check(hrDqOe == 0 && busy == 0 && overrun == 0, "R1", "oe/busy/overrun in reset",
          int'({hrDqOe, busy, overrun}), 0);
    rstN = 1;
    @(negedge clk);
    check(hrRstN == 1, "R1", "mem reset released", int'(hrRstN), 1);
  endtask

  task automatic testBasic(int line);
    int t0, len;
    int cb, ob, eb, lb, mb, ab;
    t0 = transCnt; cb = clkBad; ob = oeBad; eb = edgeBad; lb = lowBad; mb = cmdBad; ab = addrBad;
    minGap = 1000;
    fetchLine(line, len);
    repeat (2) @(negedge clk);
    check(len == BUSY_LEN, "R2", "busy length", len, BUSY_LEN);
    check(transCnt - t0 == NCHUNK, "R6", "transactions per line", transCnt - t0, NCHUNK);
    check(addrBad == ab, "R6", "chunk word address errors", addrBad - ab, 0);
    check(cmdBad == mb, "R3", "command field errors", cmdBad - mb, 0);
    check(oeBad == ob, "R3", "bus enable phase errors (R4 latency)", oeBad - ob, 0);
    check(edgeBad == eb, "R4", "edge count errors", edgeBad - eb, 0);
    check(clkBad == cb, "R7", "clock-low rule violations", clkBad - cb, 0);
    check(lowBad == lb, "R8", "cs low length errors", lowBad - lb, 0);
    check(minGap == GAP, "R8", "cs gap between chunks", minGap, GAP);
    checkLine(line, "R5");
  endtask

  task automatic testHeldHigh(int line);
    int t0, len;
    t0 = transCnt;
    lineNum = 10'(line);
    expWord = line * LINE_BYTES / 2;
    @(negedge clk) hsync = 1;
    @(negedge clk);
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
    repeat (100) @(negedge clk);
    check(transCnt - t0 == NCHUNK, "R10", "transactions with hsync held", transCnt - t0, NCHUNK);
    check(busy == 0, "R10", "no restart while held", int'(busy), 0);
    hsync = 0;
    @(negedge clk);
    checkLine(line, "R10");
  endtask

  task automatic testCollision();
    int t0, len;
    // adjacent: new edge in the first idle cycle after a fetch
    fetchLine(5, len);
    lineNum = 10'd5;
    expWord = 5 * LINE_BYTES / 2;
    hsync = 1;
    @(negedge clk) hsync = 0;
    check(busy == 1, "R2", "fetch starts in first idle cycle", int'(busy), 1);
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
    check(overrun == 0, "R9", "no overrun on adjacent edge", int'(overrun), 0);
    check(len == BUSY_LEN, "R2", "busy length of adjacent fetch", len, BUSY_LEN);
    // colliding: new edge in the last busy cycle, with a different line
    t0 = transCnt;
    lineNum = 10'd5;
    expWord = 5 * LINE_BYTES / 2;
    hsync = 1;
    @(negedge clk) hsync = 0;
    len = 1;
    while (len < BUSY_LEN) begin
      len++;
      @(negedge clk);
    end
    check(busy == 1, "R9", "still in last busy cycle", int'(busy), 1);
    lineNum = 10'd9;
    hsync = 1;
    @(negedge clk) hsync = 0;
    check(overrun == 1, "R9", "overrun on edge in last busy cycle", int'(overrun), 1);
    repeat (BUSY_LEN + 20) @(negedge clk);
    check(transCnt - t0 == NCHUNK, "R9", "no extra transactions", transCnt - t0, NCHUNK);
    checkLine(5, "R9");
    fetchLine(12, len);
    check(overrun == 1, "R9", "overrun stays set", int'(overrun), 1);
    checkLine(12, "R5");
  endtask

  initial begin
    fork
      begin
        testReset();
        repeat (5) @(negedge clk);
        testBasic(3);
        testBasic(0);
        testBasic(1023);
        testHeldHigh(17);
        testCollision();
      end
      begin
        #1000000;
        errors++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule